// File: doc/BRIEF.md
# Coast window generator

This block produces a single coast signal that tells a downstream line-locked clock when to stop tracking and hold its state. In internal mode the signal covers every horizontal line during which the already-conditioned vertical sync is active. It can also open a programmable number of lines before vertical sync and stay open a programmable number of lines after it. Both adjustments move in whole horizontal-sync periods. Opening early means the block has to predict where the next vertical sync will fall. It does this by measuring the line count of the previous frame and comparing it against the running line count of the current frame.

In external mode, a coast pin from outside the chip is brought into the clock domain through a synchroniser and sent to the output unchanged. All inputs are active high. Horizontal and vertical sync are sampled in the block's clock domain. A horizontal-sync leading edge is a cycle in which `hsync_in` is 1 and was 0 in the previous cycle. Vertical sync is sampled only in those cycles.

Top module: `coast_window_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `coast_out` is 0, and no frame length is considered measured.
- R2: With `src_ext` = 0, every horizontal-sync leading edge at which `vsync_in` is 1 drives `coast_out` to 1 in the cycle after that edge.
- R3: A vertical-sync end edge is a leading edge where `vsync_in` is 0 and was 1 at the previous leading edge. With `postcoast_lines` = P > 0, `coast_out` stays 1 through that edge and the next P−1 edges, then falls at the following edge. With P = 0 it falls at the end edge itself, unless precoast holds it.
- R4: A vertical-sync start edge is a leading edge where `vsync_in` is 1 and was 0 at the previous leading edge. Lines are numbered from that edge: the start edge is line 0 and each later leading edge adds one. With a measured previous-frame length T and `precoast_lines` = Q > 0, `coast_out` rises at the edge of line T−Q. When Q ≥ T, the window covers the whole frame.
- R5: Precoast has no effect until two vertical-sync start edges have been seen after reset. Until then, `coast_out` is 1 only during vertical sync and postcoast.
- R6: At each start edge after the first, T is updated to the distance in lines from the previous start edge. Each frame's precoast uses the most recent measurement.
- R7: With `src_ext` = 0 in the current and the previous cycle, `coast_out` changes only in the cycle after a horizontal-sync leading edge.
- R8: With `src_ext` = 1, `coast_out` equals `coast_pin` delayed by three clocks: two synchroniser stages and the output register.
- R9: The line counter saturates at 2^LINE_W − 1, so a measured T never exceeds 2^LINE_W, and the saturated value drives the precoast comparison.
- R10: A change of `src_ext` takes effect in `coast_out` one clock later. The internal window keeps running while the external source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Conditioned vertical sync, active high |
| coast_pin | input | 1 | Asynchronous external coast request |
| precoast_lines | input | ADJ_W | Lines of coast before vertical sync |
| postcoast_lines | input | ADJ_W | Lines of coast after vertical sync |
| src_ext | input | 1 | 1 selects the external pin, 0 the internal window |
| coast_out | output | 1 | Registered coast signal |

## Verification
The bench builds the block with LINE_W = 6 and the default ADJ_W = 8. With a 6-bit line counter, an 80-line frame drives the counter into saturation, which brings R9 within reach in a short run. The 8-bit adjustment values can exceed the short test frames, so the whole-frame precoast case of R4 is also reached. The frame lengths vary between 18 and 25 lines, which exercises remeasurement. Mode switches in the middle of a frame check that the internal window keeps its position while the external pin is selected.

// File: rtl/coast_pkg.sv
package coast_pkg;

    // Why the window is currently open; IDLE means coast is low.
    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_VSYNC = 2'd1,
        WIN_POST  = 2'd2,
        WIN_PRE   = 2'd3
    } win_state_t;

    // Events derived at each horizontal-sync leading edge.
    typedef struct packed {
        logic rise;      // hsync leading edge this cycle
        logic vs_now;    // vsync level sampled at this edge
        logic vs_start;  // vsync 0 at previous edge, 1 now
        logic vs_end;    // vsync 1 at previous edge, 0 now
    } hs_evt_t;

    localparam int MIN_SYNC_STAGES = 2;

    function automatic logic win_is_open(input win_state_t s);
        return s != WIN_IDLE;
    endfunction

endpackage

// File: rtl/coast_hs_events.sv
module coast_hs_events
    import coast_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hsync_i,
    input  logic    vsync_i,
    output hs_evt_t evt_o
);
    logic hs_q;
    logic vs_at_edge_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q         <= 1'b0;
            vs_at_edge_q <= 1'b0;
        end else begin
            hs_q <= hsync_i;
            if (hsync_i && !hs_q)
                vs_at_edge_q <= vsync_i;
        end
    end

    always_comb begin
        evt_o.rise     = hsync_i && !hs_q;
        evt_o.vs_now   = vsync_i;
        evt_o.vs_start = evt_o.rise && vsync_i && !vs_at_edge_q;
        evt_o.vs_end   = evt_o.rise && !vsync_i && vs_at_edge_q;
    end
endmodule

// File: rtl/coast_line_meter.sv
module coast_line_meter
    import coast_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  hs_evt_t         evt_i,
    output logic [LINE_W-1:0] pos_next_o,
    output logic [LINE_W:0]   total_o,
    output logic            valid_o
);
    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] cnt_q;
    logic [LINE_W:0]   total_q;
    logic              seen_q;
    logic              valid_q;

    // Line number the current edge will carry if it is not a frame start.
    assign pos_next_o = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign total_o    = total_q;
    assign valid_o    = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            total_q <= '0;
            seen_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (evt_i.rise) begin
            if (evt_i.vs_start) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
                if (seen_q) begin
                    total_q <= {1'b0, cnt_q} + 1'b1;
                    valid_q <= 1'b1;
                end
            end else begin
                cnt_q <= pos_next_o;
            end
        end
    end
endmodule

// File: rtl/coast_window_ctl.sv
module coast_window_ctl
    import coast_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int ADJ_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  hs_evt_t           evt_i,
    input  logic [LINE_W-1:0] pos_next_i,
    input  logic [LINE_W:0]   total_i,
    input  logic              valid_i,
    input  logic [ADJ_W-1:0]  pre_i,
    input  logic [ADJ_W-1:0]  post_i,
    output win_state_t        state_d_o
);
    localparam int WIDE_W = ((LINE_W + 1 > ADJ_W) ? LINE_W + 1 : ADJ_W) + 1;

    win_state_t       state_q, state_d;
    logic [ADJ_W-1:0] rem_q, rem_d;
    logic [WIDE_W-1:0] reach;
    logic             pre_hit;

    // Early opening: current position plus lead reaches last frame's length.
    assign reach   = WIDE_W'(pos_next_i) + WIDE_W'(pre_i);
    assign pre_hit = valid_i && (pre_i != '0) && (reach >= WIDE_W'(total_i));

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        if (evt_i.rise) begin
            if (evt_i.vs_now) begin
                state_d = WIN_VSYNC;
                rem_d   = '0;
            end else if (evt_i.vs_end) begin
                if (post_i != '0) begin
                    state_d = WIN_POST;
                    rem_d   = post_i - 1'b1;
                end else begin
                    state_d = pre_hit ? WIN_PRE : WIN_IDLE;
                end
            end else if (rem_q != '0) begin
                state_d = WIN_POST;
                rem_d   = rem_q - 1'b1;
            end else begin
                state_d = pre_hit ? WIN_PRE : WIN_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    assign state_d_o = state_d;
endmodule

// File: rtl/coast_sync.sv
module coast_sync
    import coast_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int N = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= d_i;
    end

    for (genvar i = 1; i < N; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[N-1];
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
    import coast_pkg::*;
#(
    parameter int LINE_W      = 12,
    parameter int ADJ_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             coast_pin,
    input  logic [ADJ_W-1:0] precoast_lines,
    input  logic [ADJ_W-1:0] postcoast_lines,
    input  logic             src_ext,
    output logic             coast_out
);
    hs_evt_t           evt;
    logic [LINE_W-1:0] pos_next;
    logic [LINE_W:0]   total;
    logic              valid;
    win_state_t        win_d;
    logic              ext_s;
    logic              out_q;

    coast_hs_events u_evt (
        .clk     (clk),
        .rst     (rst),
        .hsync_i (hsync_in),
        .vsync_i (vsync_in),
        .evt_o   (evt)
    );

    coast_line_meter #(.LINE_W(LINE_W)) u_meter (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .pos_next_o (pos_next),
        .total_o    (total),
        .valid_o    (valid)
    );

    coast_window_ctl #(.LINE_W(LINE_W), .ADJ_W(ADJ_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .pos_next_i (pos_next),
        .total_i    (total),
        .valid_i    (valid),
        .pre_i      (precoast_lines),
        .post_i     (postcoast_lines),
        .state_d_o  (win_d)
    );

    coast_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (coast_pin),
        .q_o (ext_s)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= src_ext ? ext_s : win_is_open(win_d);
    end

    assign coast_out = out_q;
endmodule

// File: rtl/coast_window_gen_chk.sv
module coast_window_gen_chk #(
    parameter int ADJ_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hsync_in,
    input logic             vsync_in,
    input logic             coast_pin,
    input logic [ADJ_W-1:0] precoast_lines,
    input logic [ADJ_W-1:0] postcoast_lines,
    input logic             src_ext,
    input logic             coast_out
);
    logic       hs_prev;
    logic       vs_prev_edge;
    logic       ext_prev;
    logic [1:0] age;
    logic       hs_rise;

    assign hs_rise = hsync_in && !hs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_prev      <= 1'b0;
            vs_prev_edge <= 1'b0;
            ext_prev     <= 1'b0;
            age          <= '0;
        end else begin
            hs_prev  <= hsync_in;
            ext_prev <= src_ext;
            if (hs_rise) vs_prev_edge <= vsync_in;
            if (age != 2'd3) age <= age + 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !coast_out); // R1

    AST_VSYNC_LINES: assert property (@(posedge clk) disable iff (rst)
        (hs_rise && vsync_in && !src_ext) |=> coast_out); // R2

    AST_POST_ZERO_CLOSE: assert property (@(posedge clk) disable iff (rst)
        (hs_rise && !vsync_in && vs_prev_edge && !src_ext &&
         postcoast_lines == '0 && precoast_lines == '0) |=> !coast_out); // R3

    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!src_ext && !ext_prev && !hs_rise) |=> $stable(coast_out)); // R7

    AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (src_ext && age == 2'd3) |=> (coast_out == $past(coast_pin, 3))); // R8

endmodule

bind coast_window_gen coast_window_gen_chk #(.ADJ_W(ADJ_W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .hsync_in        (hsync_in),
    .vsync_in        (vsync_in),
    .coast_pin       (coast_pin),
    .precoast_lines  (precoast_lines),
    .postcoast_lines (postcoast_lines),
    .src_ext         (src_ext),
    .coast_out       (coast_out)
);

// File: tb/coast_window_gen_tb_top.sv
`timescale 1ns/1ps
module coast_window_gen_tb_top;
    localparam int LINE_W = 6;
    localparam int ADJ_W  = 8;
    localparam int CMAX   = (1 << LINE_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hsync_in = 1'b0;
    logic             vsync_in = 1'b0;
    logic             coast_pin = 1'b0;
    logic [ADJ_W-1:0] precoast_lines = '0;
    logic [ADJ_W-1:0] postcoast_lines = '0;
    logic             src_ext = 1'b0;
    logic             coast_out;

    always #2.5 clk = ~clk;

    coast_window_gen #(.LINE_W(LINE_W), .ADJ_W(ADJ_W)) dut_i (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .coast_pin(coast_pin), .precoast_lines(precoast_lines),
        .postcoast_lines(postcoast_lines), .src_ext(src_ext),
        .coast_out(coast_out)
    );

    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    int m_hs, m_e1, m_e2, m_exp, m_cnt, m_total, m_seen, m_valid, m_vsp, m_rem, m_win;

    always @(posedge clk) begin
        if (rst) begin
            m_hs = 0; m_e1 = 0; m_e2 = 0; m_exp = 0; m_cnt = 0; m_total = 0;
            m_seen = 0; m_valid = 0; m_vsp = 0; m_rem = 0; m_win = 0;
        end else begin
            if (hsync_in && m_hs == 0) begin
                int nx;
                int hit;
                nx  = (m_cnt + 1 > CMAX) ? CMAX : m_cnt + 1;
                hit = (m_valid != 0 && precoast_lines != 0 &&
                       nx + int'(precoast_lines) >= m_total) ? 1 : 0;
                if (vsync_in) begin
                    m_win = 1; m_rem = 0;
                end else if (m_vsp != 0) begin
                    if (postcoast_lines != 0) begin
                        m_win = 1; m_rem = int'(postcoast_lines) - 1;
                    end else m_win = hit;
                end else if (m_rem > 0) begin
                    m_win = 1; m_rem--;
                end else m_win = hit;
                if (vsync_in && m_vsp == 0) begin
                    if (m_seen != 0) begin m_total = m_cnt + 1; m_valid = 1; end
                    m_seen = 1; m_cnt = 0;
                end else m_cnt = nx;
                m_vsp = vsync_in ? 1 : 0;
            end
            m_exp = src_ext ? m_e2 : m_win;
            m_e2 = m_e1;
            m_e1 = coast_pin ? 1 : 0;
            m_hs = hsync_in ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (coast_out !== m_exp[0]) begin
                n_fail++;
                $display("FAIL %s t=%0t coast_out=%0b expected=%0b", cur_req, $time, coast_out, m_exp[0]);
            end
        end
    end

    task automatic run_line(input bit vs);
        vsync_in = vs;
        hsync_in = 1'b1;
        repeat (2) @(negedge clk);
        hsync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input int lines, input int vs_lines);
        for (int i = 0; i < lines; i++) run_line(i < vs_lines);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";                       // reset state
        rst = 1'b0;
        repeat (3) @(negedge clk);
        cur_req = "R5";                       // precoast ignored before measurement
        precoast_lines = 8'd4;
        run_frame(20, 3);
        cur_req = "R2";                       // vsync lines covered
        precoast_lines = 8'd0;
        run_frame(20, 3);
        run_frame(20, 3);
        cur_req = "R3";                       // postcoast extension
        postcoast_lines = 8'd2;
        run_frame(20, 3);
        postcoast_lines = 8'd5;
        run_frame(20, 2);
        cur_req = "R4";                       // precoast opening
        precoast_lines = 8'd3;
        postcoast_lines = 8'd0;
        run_frame(20, 3);
        run_frame(20, 3);
        precoast_lines = 8'd1;
        postcoast_lines = 8'd1;
        run_frame(20, 3);
        precoast_lines = 8'd30;               // larger than frame: whole frame
        run_frame(20, 3);
        run_frame(20, 3);
        cur_req = "R6";                       // frame length changes
        precoast_lines = 8'd4;
        run_frame(25, 3);
        run_frame(25, 3);
        run_frame(18, 2);
        run_frame(18, 2);
        cur_req = "R7";                       // mid-line stability
        postcoast_lines = 8'd3;
        run_frame(22, 4);
        cur_req = "R8";                       // external pin follows
        src_ext = 1'b1;
        for (int i = 0; i < 60; i++) begin
            coast_pin = (i % 7 < 3) ? 1'b1 : 1'b0;
            if (i % 6 == 0) hsync_in = 1'b1;
            if (i % 6 == 2) hsync_in = 1'b0;
            @(negedge clk);
        end
        hsync_in = 1'b0;
        cur_req = "R10";                      // switching mid-frame
        for (int f = 0; f < 2; f++) begin
            for (int i = 0; i < 22; i++) begin
                src_ext = ((i / 5) % 2 == 1);
                coast_pin = (i % 3 == 0);
                run_line(i < 3);
            end
        end
        src_ext = 1'b0;
        cur_req = "R9";                       // counter saturation
        precoast_lines = 8'd3;
        postcoast_lines = 8'd0;
        run_frame(80, 3);
        run_frame(80, 3);
        run_frame(80, 3);
        cur_req = "R1";                       // reset in the middle
        run_frame(10, 0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R5";
        run_frame(20, 3);
        run_frame(20, 3);
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired during %s, actual=running expected=finished", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule